// File: doc/BRIEF.md
# Trap Entry Sequencer for a Windowed Register File

This block carries out the state changes a processor with rotating register windows makes when it enters a trap. A trap request comes with an 8-bit trap number and a snapshot of the current architectural state: the program counter pair, the current window pointer, the supervisor and trap-enable bits, and the trap base register. One clock edge later the block presents the complete post-trap state and pulses a completion strobe. Surrounding logic uses that strobe to commit the new values and to write the two saved program counters into the register file.

The window pointer steps down by one, wrapping from window zero to the highest window. Each window owns a group of 16 physical registers, and the two save addresses are computed inside the new window's group. The trap base register keeps its base field, and its trap-type field is replaced by the trap number. Execution resumes at the vector the base register now holds.

When traps are disabled, a request does not vector. It moves the block into a sticky error state that only reset clears. Choosing which trap to take is done outside this block, and so is the register file.

Top module: `trap_entry_seq`

## Requirements
- R1: After synchronous active-low reset, trap_done, err_state, nxt_cwp, save_addr_a, save_addr_b, save_data_a, save_data_b, nxt_pc, nxt_npc, nxt_tbr, nxt_s, nxt_ps and nxt_et are all zero.
- R2: For an accepted trap, nxt_cwp equals (cur_cwp - 1) modulo NWIN, so window 0 becomes window NWIN-1.
- R3: For an accepted trap, save_data_a equals cur_pc and save_data_b equals cur_npc. save_addr_a equals nxt_cwp*16 + SAVE_SLOT and save_addr_b equals that value plus 1, both taken modulo NWIN*16 (defaults NWIN=8, SAVE_SLOT=9).
- R4: For an accepted trap, nxt_ps equals cur_s and nxt_s is 1.
- R5: For an accepted trap, nxt_et is 0.
- R6: For an accepted trap, nxt_tbr[31:12] equals cur_tbr[31:12], nxt_tbr[11:4] equals trap_type, and nxt_tbr[3:0] is 0.
- R7: For an accepted trap, nxt_pc equals nxt_tbr and nxt_npc equals nxt_tbr + 4.
- R8: A request is accepted when trap_req is high at a clock edge, cur_et is 1 and err_state is 0. trap_done is then high for exactly the following cycle, and all outputs hold until the next accepted trap.
- R9: A request with cur_et at 0 while err_state is 0 sets err_state at that edge. trap_done stays low and the other outputs keep their values. err_state stays high until reset.
- R10: While err_state is high, every request is ignored: trap_done stays low and all other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled at each clock edge |
| trap_type | input | 8 | Trap number |
| cur_pc | input | 32 | Current program counter |
| cur_npc | input | 32 | Current next program counter |
| cur_cwp | input | 3 | Current window pointer |
| cur_s | input | 1 | Current supervisor bit |
| cur_et | input | 1 | Current trap-enable bit |
| cur_tbr | input | 32 | Current trap base register |
| trap_done | output | 1 | One-cycle completion strobe, also the register-file write strobe |
| err_state | output | 1 | Sticky error state |
| nxt_cwp | output | 3 | New window pointer |
| save_addr_a | output | 7 | Physical register address for the saved PC |
| save_data_a | output | 32 | Saved PC value |
| save_addr_b | output | 7 | Physical register address for the saved next PC |
| save_data_b | output | 32 | Saved next PC value |
| nxt_pc | output | 32 | New program counter |
| nxt_npc | output | 32 | New next program counter |
| nxt_tbr | output | 32 | Updated trap base register |
| nxt_s | output | 1 | New supervisor bit |
| nxt_ps | output | 1 | New previous-supervisor bit |
| nxt_et | output | 1 | New trap-enable bit |

## Verification
The bench targets the window wrap from 0 to 7. A design that decrements without wrapping, or that increments, would present a wrong window and wrong save addresses there. It also uses trap numbers and base values with every bit set or clear, which exposes a shift that is off by one position, a base field that is not preserved, or low bits that are not cleared. The previous-supervisor bit is checked with the supervisor bit both 0 and 1, so a design that just copies the new supervisor value into it is caught. Finally, the bench raises a trap with traps disabled and then sends further requests. A design that still vectors, pulses done, or leaves the error state would change the held outputs or the strobe.

// File: rtl/trap_entry_pkg.sv
// Package: shared types for the trap entry sequencer.
// Assumes: processor state bits are handled as a single packed group.
package trap_entry_pkg;

    // Processor state bits touched at trap entry.
    typedef struct packed {
        logic sup;       // supervisor
        logic prev_sup;  // previous supervisor
        logic trap_en;   // traps enabled
    } psr_bits_t;

    // Size of one window's register group, as a power of two.
    localparam int unsigned GRP_LG = 4;

endpackage

// File: rtl/trap_win_rot.sv
// Module: trap_win_rot
// Rotates the window pointer down by one and forms the two physical
// register addresses where the program counters are saved.
// Assumes: NWIN is a power of two, so wrap-around is plain truncation;
// the register file holds NWIN groups of 2**GRP_LG registers, so the
// address width truncation also wraps the last window onto the first.
module trap_win_rot
    import trap_entry_pkg::*;
#(
    parameter int unsigned NWIN      = 8,
    parameter int unsigned SAVE_SLOT = 9,
    localparam int unsigned CWP_W    = $clog2(NWIN),
    localparam int unsigned RA_W     = CWP_W + GRP_LG
) (
    input  logic [CWP_W-1:0] cwp_in,
    output logic [CWP_W-1:0] cwp_out,
    output logic [RA_W-1:0]  addr_a,
    output logic [RA_W-1:0]  addr_b
);
    localparam logic [RA_W-1:0] SLOT_A = RA_W'(SAVE_SLOT);
    localparam logic [RA_W-1:0] SLOT_B = RA_W'(SAVE_SLOT + 1);

    logic [RA_W-1:0] grp_base;

    // Decrement with wrap, then place both save slots in the new group.
    always_comb begin
        cwp_out  = cwp_in - CWP_W'(1);
        grp_base = {cwp_out, {GRP_LG{1'b0}}};
        addr_a   = grp_base + SLOT_A;
        addr_b   = grp_base + SLOT_B;
    end
endmodule

// File: rtl/trap_vec_calc.sv
// Module: trap_vec_calc
// Builds the updated trap base register and the vector PC pair.
// Assumes: the trap-type field sits just above TT_LSB zero bits and the
// base field fills everything above the trap-type field.
module trap_vec_calc #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned TT_W   = 8,
    parameter int unsigned TT_LSB = 4,
    parameter int unsigned STEP   = 4,
    localparam int unsigned BASE_LSB = TT_LSB + TT_W
) (
    input  logic [XLEN-1:BASE_LSB] base_in,
    input  logic [TT_W-1:0]        tt_in,
    output logic [XLEN-1:0]        tbr_out,
    output logic [XLEN-1:0]        pc_out,
    output logic [XLEN-1:0]        npc_out
);
    // Keep the base, insert the trap number, clear the low bits; vector there.
    always_comb begin
        tbr_out = {base_in, tt_in, {TT_LSB{1'b0}}};
        pc_out  = tbr_out;
        npc_out = tbr_out + XLEN'(STEP);
    end
endmodule

// File: rtl/trap_psr_upd.sv
// Module: trap_psr_upd
// Computes the processor state bits after trap entry.
// Assumes: called only for a trap that is taken (traps enabled).
module trap_psr_upd
    import trap_entry_pkg::*;
(
    input  logic      cur_sup,
    output psr_bits_t psr_out
);
    // Save the old supervisor bit, enter supervisor, disable traps.
    always_comb begin
        psr_out.prev_sup = cur_sup;
        psr_out.sup      = 1'b1;
        psr_out.trap_en  = 1'b0;
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Module: trap_entry_seq (top)
// Trap entry sequencer: on an accepted request, registers the new window
// pointer, save addresses and data, vector PC pair, trap base register and
// state bits, and pulses trap_done for one cycle. A request with traps
// disabled latches a sticky error state instead.
// Assumes: trap_req is presented with a stable state snapshot at the edge;
// prioritisation and the register file live outside this block.
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned TT_W      = 8,
    parameter int unsigned TT_LSB    = 4,
    parameter int unsigned NWIN      = 8,
    parameter int unsigned SAVE_SLOT = 9,
    localparam int unsigned CWP_W    = $clog2(NWIN),
    localparam int unsigned RA_W     = CWP_W + GRP_LG,
    localparam int unsigned BASE_LSB = TT_LSB + TT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [TT_W-1:0]  trap_type,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_npc,
    input  logic [CWP_W-1:0] cur_cwp,
    input  logic             cur_s,
    input  logic             cur_et,
    input  logic [XLEN-1:0]  cur_tbr,
    output logic             trap_done,
    output logic             err_state,
    output logic [CWP_W-1:0] nxt_cwp,
    output logic [RA_W-1:0]  save_addr_a,
    output logic [XLEN-1:0]  save_data_a,
    output logic [RA_W-1:0]  save_addr_b,
    output logic [XLEN-1:0]  save_data_b,
    output logic [XLEN-1:0]  nxt_pc,
    output logic [XLEN-1:0]  nxt_npc,
    output logic [XLEN-1:0]  nxt_tbr,
    output logic             nxt_s,
    output logic             nxt_ps,
    output logic             nxt_et
);
    logic [CWP_W-1:0] rot_cwp;
    logic [RA_W-1:0]  rot_addr_a;
    logic [RA_W-1:0]  rot_addr_b;
    logic [XLEN-1:0]  vec_tbr;
    logic [XLEN-1:0]  vec_pc;
    logic [XLEN-1:0]  vec_npc;
    psr_bits_t        upd_psr;
    logic             take_trap;
    logic             go_error;
    logic             tbr_lo_unused;

    // The low bits of the incoming base register are rewritten, never read.
    assign tbr_lo_unused = ^cur_tbr[BASE_LSB-1:0];

    trap_win_rot #(
        .NWIN      (NWIN),
        .SAVE_SLOT (SAVE_SLOT)
    ) u_rot (
        .cwp_in  (cur_cwp),
        .cwp_out (rot_cwp),
        .addr_a  (rot_addr_a),
        .addr_b  (rot_addr_b)
    );

    trap_vec_calc #(
        .XLEN   (XLEN),
        .TT_W   (TT_W),
        .TT_LSB (TT_LSB)
    ) u_vec (
        .base_in (cur_tbr[XLEN-1:BASE_LSB]),
        .tt_in   (trap_type),
        .tbr_out (vec_tbr),
        .pc_out  (vec_pc),
        .npc_out (vec_npc)
    );

    trap_psr_upd u_psr (
        .cur_sup (cur_s),
        .psr_out (upd_psr)
    );

    // Classify the request: a taken trap, or entry into the error state.
    always_comb begin
        take_trap = trap_req && !err_state && cur_et;
        go_error  = trap_req && !err_state && !cur_et;
    end

    // Completion strobe and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_done <= 1'b0;
            err_state <= 1'b0;
        end else begin
            trap_done <= take_trap;
            if (go_error) err_state <= 1'b1;
        end
    end

    // Post-trap state registers, loaded only when a trap is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_cwp     <= '0;
            save_addr_a <= '0;
            save_addr_b <= '0;
            save_data_a <= '0;
            save_data_b <= '0;
            nxt_pc      <= '0;
            nxt_npc     <= '0;
            nxt_tbr     <= '0;
            nxt_s       <= 1'b0;
            nxt_ps      <= 1'b0;
            nxt_et      <= 1'b0;
        end else if (take_trap) begin
            nxt_cwp     <= rot_cwp;
            save_addr_a <= rot_addr_a;
            save_addr_b <= rot_addr_b;
            save_data_a <= cur_pc;
            save_data_b <= cur_npc;
            nxt_pc      <= vec_pc;
            nxt_npc     <= vec_npc;
            nxt_tbr     <= vec_tbr;
            nxt_s       <= upd_psr.sup;
            nxt_ps      <= upd_psr.prev_sup;
            nxt_et      <= upd_psr.trap_en;
        end
    end
endmodule

// File: rtl/trap_entry_seq_chk.sv
// Module: trap_entry_seq_chk
// Property checker for trap_entry_seq, attached with bind below.
// Assumes: default parameters of the top (XLEN=32, NWIN=8).
module trap_entry_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_req,
    input logic [7:0]  trap_type,
    input logic [2:0]  cur_cwp,
    input logic        cur_s,
    input logic        cur_et,
    input logic        trap_done,
    input logic        err_state,
    input logic [2:0]  nxt_cwp,
    input logic [6:0]  save_addr_a,
    input logic [6:0]  save_addr_b,
    input logic [31:0] nxt_pc,
    input logic [31:0] nxt_npc,
    input logic [31:0] nxt_tbr,
    input logic        nxt_s,
    input logic        nxt_ps,
    input logic        nxt_et
);
    assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_et && !err_state) |=> trap_done);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req || !cur_et || err_state) |=> !trap_done);

    assert_cwp_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_et && !err_state) |=> (nxt_cwp == $past(cur_cwp) - 3'd1));

    assert_save_adj_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |-> (save_addr_b == save_addr_a + 7'd1));

    assert_psr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_et && !err_state) |=> (nxt_s && nxt_ps == $past(cur_s)));

    assert_et_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |-> !nxt_et);

    assert_tt_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_et && !err_state) |=> (nxt_tbr[11:4] == $past(trap_type) && nxt_tbr[3:0] == 4'd0));

    assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_done |-> (nxt_pc == nxt_tbr && nxt_npc == nxt_pc + 32'd4));

    assert_err_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !cur_et && !err_state) |=> err_state);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |=> err_state);

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |=> ($stable(nxt_pc) && $stable(nxt_tbr) && $stable(nxt_cwp) && !trap_done));
endmodule

bind trap_entry_seq trap_entry_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_req    (trap_req),
    .trap_type   (trap_type),
    .cur_cwp     (cur_cwp),
    .cur_s       (cur_s),
    .cur_et      (cur_et),
    .trap_done   (trap_done),
    .err_state   (err_state),
    .nxt_cwp     (nxt_cwp),
    .save_addr_a (save_addr_a),
    .save_addr_b (save_addr_b),
    .nxt_pc      (nxt_pc),
    .nxt_npc     (nxt_npc),
    .nxt_tbr     (nxt_tbr),
    .nxt_s       (nxt_s),
    .nxt_ps      (nxt_ps),
    .nxt_et      (nxt_et)
);

// File: tb/trap_entry_seq_tb_top.sv
`timescale 1ns/1ps
module trap_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_type = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_npc = '0;
    logic [2:0]  cur_cwp = '0;
    logic        cur_s = 1'b0;
    logic        cur_et = 1'b0;
    logic [31:0] cur_tbr = '0;
    logic        trap_done, err_state, nxt_s, nxt_ps, nxt_et;
    logic [2:0]  nxt_cwp;
    logic [6:0]  save_addr_a, save_addr_b;
    logic [31:0] save_data_a, save_data_b, nxt_pc, nxt_npc, nxt_tbr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    trap_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_cwp(cur_cwp), .cur_s(cur_s),
        .cur_et(cur_et), .cur_tbr(cur_tbr), .trap_done(trap_done),
        .err_state(err_state), .nxt_cwp(nxt_cwp), .save_addr_a(save_addr_a),
        .save_data_a(save_data_a), .save_addr_b(save_addr_b),
        .save_data_b(save_data_b), .nxt_pc(nxt_pc), .nxt_npc(nxt_npc),
        .nxt_tbr(nxt_tbr), .nxt_s(nxt_s), .nxt_ps(nxt_ps), .nxt_et(nxt_et)
    );

    localparam int NV = 6;
    localparam logic [2:0]  V_CWP [NV] = '{3'd0, 3'd7, 3'd3, 3'd1, 3'd5, 3'd2};
    localparam logic [7:0]  V_TT  [NV] = '{8'h00, 8'hFF, 8'h11, 8'h80, 8'h5A, 8'h01};
    localparam logic        V_S   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [31:0] V_PC  [NV] = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h4000_0010,
                                           32'h0000_0004, 32'h8765_4320, 32'h0012_3458};
    localparam logic [31:0] V_NPC [NV] = '{32'h0000_1004, 32'h0000_0000, 32'h4000_0014,
                                           32'h0000_0008, 32'h8765_4324, 32'h0012_345C};
    localparam logic [31:0] V_TBR [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hABCD_E123,
                                           32'h1234_5FFF, 32'hFFFF_F000, 32'h0000_1ABC};

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one request for one edge, then check the registered results.
    task automatic run_trap(input logic [2:0] cwp, input logic [7:0] tt, input logic s,
                            input logic et, input logic [31:0] pc, input logic [31:0] npc,
                            input logic [31:0] tbr);
        @(negedge clk);
        trap_req = 1'b1; cur_cwp = cwp; trap_type = tt; cur_s = s; cur_et = et;
        cur_pc = pc; cur_npc = npc; cur_tbr = tbr;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R8 watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] etbr;
        logic [2:0]  ecwp;
        logic [6:0]  ea;
        logic [31:0] hold_pc, hold_tbr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "done", 32'(trap_done), 0);
        chk("R1", "err", 32'(err_state), 0);
        chk("R1", "pc", nxt_pc, 0);
        chk("R1", "tbr", nxt_tbr, 0);
        chk("R1", "cwp", 32'(nxt_cwp), 0);
        chk("R1", "state", {29'd0, nxt_s, nxt_ps, nxt_et}, 0);

        for (int i = 0; i < NV; i++) begin
            ecwp = V_CWP[i] - 3'd1;
            etbr = {V_TBR[i][31:12], V_TT[i], 4'h0};
            ea   = {ecwp, 4'h0} + 7'd9;
            run_trap(V_CWP[i], V_TT[i], V_S[i], 1'b1, V_PC[i], V_NPC[i], V_TBR[i]);
            chk("R8", "done pulse", 32'(trap_done), 1);
            chk("R2", "cwp", 32'(nxt_cwp), 32'(ecwp));
            chk("R3", "addr a", 32'(save_addr_a), 32'(ea));
            chk("R3", "addr b", 32'(save_addr_b), 32'(ea + 7'd1));
            chk("R3", "data a", save_data_a, V_PC[i]);
            chk("R3", "data b", save_data_b, V_NPC[i]);
            chk("R4", "s", 32'(nxt_s), 1);
            chk("R4", "ps", 32'(nxt_ps), 32'(V_S[i]));
            chk("R5", "et", 32'(nxt_et), 0);
            chk("R6", "tbr", nxt_tbr, etbr);
            chk("R7", "pc", nxt_pc, etbr);
            chk("R7", "npc", nxt_npc, etbr + 32'd4);
            @(negedge clk);
            chk("R8", "done low", 32'(trap_done), 0);
            chk("R8", "pc held", nxt_pc, etbr);
        end

        // R9: request with traps disabled enters error state
        hold_pc = nxt_pc; hold_tbr = nxt_tbr;
        run_trap(3'd4, 8'h33, 1'b0, 1'b0, 32'h1111_0000, 32'h1111_0004, 32'h2222_2000);
        chk("R9", "err set", 32'(err_state), 1);
        chk("R9", "no done", 32'(trap_done), 0);
        chk("R9", "pc held", nxt_pc, hold_pc);
        chk("R9", "tbr held", nxt_tbr, hold_tbr);
        @(negedge clk);
        chk("R9", "err sticky", 32'(err_state), 1);

        // R10: enabled request ignored while in error state
        run_trap(3'd6, 8'h44, 1'b1, 1'b1, 32'h3333_0000, 32'h3333_0004, 32'h5555_5000);
        chk("R10", "no done", 32'(trap_done), 0);
        chk("R10", "pc held", nxt_pc, hold_pc);
        chk("R10", "cwp held", 32'(nxt_cwp), 32'(V_CWP[NV-1] - 3'd1));
        chk("R10", "err still", 32'(err_state), 1);

        // R1: reset clears the error state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1", "err cleared", 32'(err_state), 0);
        chk("R1", "pc cleared", nxt_pc, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule